// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the timing for a serial audio or codec port. It divides the system clock into a serial bit clock and emits a one-cycle strobe on every rising bit-clock edge. It counts those bit-clock ticks to shape a frame sync signal. The frame length, the number of ticks for which the sync is asserted, and the level the sync takes when asserted are all programmable. Each length field uses a plus-one encoding. One instance can therefore drive a one-tick codec sync pulse or a 50% left/right word-select square wave.

In free-running mode a new frame begins as soon as the previous one ends, whatever the state of the transmit side. With free-running mode off, the generator sits idle with the sync deasserted until the transmit side reports pending data. The frame then opens on the next bit-clock tick. New settings are taken only when a frame opens or while the generator is idle, so a frame in progress always completes with the settings it started with. The port's shifters, which sit outside this block, align to `frame_start` and `bclk_tick`.

Top module: `fsync_gen`

## Requirements
- R1: While reset is held, `bclk`, `bclk_tick` and `frame_start` are 0 and `fsync` is 0.
- R2: Each half of the `bclk` period lasts `cfg_clk_div`+1 clock cycles. `bclk_tick` is high for exactly the one clock cycle in which `bclk` becomes 1, so consecutive ticks are 2×(`cfg_clk_div`+1) clock cycles apart.
- R3: While frames run back to back, consecutive frames start `cfg_frame_len`+1 bit-clock ticks apart.
- R4: `fsync` is asserted for exactly `cfg_sync_len`+1 ticks, starting with the frame's first tick.
- R5: With `cfg_active_high`=1 the asserted level of `fsync` is 1. With `cfg_active_high`=0 the asserted level is 0, and the deasserted level is the opposite one in both cases.
- R6: When `cfg_sync_len` ≥ `cfg_frame_len`, `fsync` stays asserted for every tick of every frame.
- R7: With `cfg_free_run`=0 and `tx_pending`=0, once the current frame ends no `frame_start` occurs and `fsync` stays deasserted.
- R8: From idle, when `tx_pending` is 1 in the cycle before a tick, that tick opens a frame and carries `frame_start`.
- R9: When `tx_pending` falls during a frame with `cfg_free_run`=0, that frame still delivers its full sync width, and no further frame starts.
- R10: Changes to `cfg_frame_len`, `cfg_sync_len`, `cfg_clk_div` or `cfg_active_high` made mid-frame leave the current frame's length and tick spacing unchanged. They apply from the next frame onward.
- R11: With `cfg_frame_len`=2N−1 and `cfg_sync_len`=N−1, `fsync` is asserted for N ticks and deasserted for N ticks. A frame then lasts 2N×2×(`cfg_clk_div`+1) clock cycles.
- R12: `frame_start` is a single-cycle pulse that always coincides with `bclk_tick`, and `fsync` is at its asserted level in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clk_div | input | DIV_W | Half-period of the bit clock minus one, in clock cycles |
| cfg_frame_len | input | CNT_W | Frame length minus one, in bit-clock ticks |
| cfg_sync_len | input | CNT_W | Sync asserted width minus one, in ticks |
| cfg_active_high | input | 1 | 1: sync asserted high; 0: asserted low |
| cfg_free_run | input | 1 | 1: frames run continuously; 0: frames wait on tx_pending |
| tx_pending | input | 1 | Transmit data is waiting to be sent |
| bclk | output | 1 | Serial bit clock |
| bclk_tick | output | 1 | One-cycle strobe on each rising bclk |
| fsync | output | 1 | Frame sync / word select |
| frame_start | output | 1 | One-cycle strobe on the first tick of each frame |

## Verification
The end of one frame and the opening of the next happen on the same tick. A settings reload happens on that tick too. The bench provokes this case by changing the frame length and the divider in the middle of a free-running frame. It then checks two things: the tick count and tick spacing of that frame still match the old settings, and the very next frame shows the new ones. The second coincidence pits the frame boundary against a falling `tx_pending`. The bench drops `tx_pending` right after a frame opens. It then checks that the full sync width still appears and that no `frame_start` follows.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   typedef enum logic {
      FSG_IDLE = 1'b0,
      FSG_RUN  = 1'b1
   } fsg_state_e;

   // Map an internal "asserted" flag onto the pin level for the given polarity.
   function automatic logic fsg_level(input logic asserted, input logic active_high);
      return active_high ? asserted : ~asserted;
   endfunction

endpackage

// File: rtl/fsg_shadow.sv
module fsg_shadow #(
   parameter int DIV_W = 8,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] cfg_clk_div,
   input  logic [CNT_W-1:0] cfg_frame_len,
   input  logic [CNT_W-1:0] cfg_sync_len,
   input  logic             cfg_active_high,
   output logic [DIV_W-1:0] act_div,
   output logic [CNT_W-1:0] act_len,
   output logic [CNT_W-1:0] act_wid,
   output logic             act_pol
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_div <= '0;
         act_len <= '0;
         act_wid <= '0;
         act_pol <= 1'b1;
      end else if (load) begin
         act_div <= cfg_clk_div;
         act_len <= cfg_frame_len;
         act_wid <= cfg_sync_len;
         act_pol <= cfg_active_high;
      end
   end

   // R10: working settings move only when a reload is requested
   a_r10_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_len) && $stable(act_wid) && $stable(act_div) && $stable(act_pol)));

endmodule

// File: rtl/fsg_bitclk.sv
module fsg_bitclk #(
   parameter int DIV_W     = 8,
   parameter bit TICK_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] act_div,
   output logic             bclk,
   output logic             bclk_tick,
   output logic             tick_next
);

   logic [DIV_W-1:0] phase_cnt;
   logic             phase_done;

   assign phase_done = (phase_cnt >= act_div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_cnt <= '0;
         bclk      <= 1'b0;
      end else if (phase_done) begin
         phase_cnt <= '0;
         bclk      <= ~bclk;
      end else begin
         phase_cnt <= phase_cnt + 1'b1;
      end
   end

   generate
      if (TICK_RISE) begin : g_rise
         assign tick_next = phase_done & ~bclk;
         // R2: tick marks a rising bit-clock edge
         a_r2_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            bclk_tick |-> (bclk && !$past(bclk)));
      end else begin : g_fall
         assign tick_next = phase_done & bclk;
         a_r2_tick_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
            bclk_tick |-> (!bclk && $past(bclk)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_tick <= 1'b0;
      else        bclk_tick <= tick_next;
   end

endmodule

// File: rtl/fsg_framer.sv
module fsg_framer
   import fsg_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_next,
   input  logic             free_run,
   input  logic             pending,
   input  logic [CNT_W-1:0] act_len,
   input  logic [CNT_W-1:0] act_wid,
   input  logic             act_pol,
   output logic             running,
   output logic             load,
   output logic             frame_start,
   output logic             fsync
);

   fsg_state_e       state;
   logic [CNT_W-1:0] pos;
   logic             want_frame;
   logic             at_end;
   logic             open_now;
   logic             close_now;
   logic             asserted;

   assign running    = (state == FSG_RUN);
   assign want_frame = free_run | pending;
   assign at_end     = running & (pos >= act_len);
   assign open_now   = tick_next & want_frame & (~running | at_end);
   assign close_now  = tick_next & ~want_frame & at_end;
   assign load       = ~running | open_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= FSG_IDLE;
         pos         <= '0;
         frame_start <= 1'b0;
      end else begin
         frame_start <= open_now;
         if (open_now) begin
            state <= FSG_RUN;
            pos   <= '0;
         end else if (close_now) begin
            state <= FSG_IDLE;
            pos   <= '0;
         end else if (tick_next && running) begin
            pos <= pos + 1'b1;
         end
      end
   end

   // Width at or beyond the frame length keeps the sync asserted all frame.
   assign asserted = running & (pos <= act_wid);
   assign fsync    = fsg_level(asserted, act_pol);

   // R3: position never runs past the frame length
   a_r3_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (pos <= act_len));
   // R4: a frame opens with the sync asserted
   a_r4_open_asserted: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (running && fsync == act_pol));

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
   parameter int DIV_W     = 8,
   parameter int CNT_W     = 10,
   parameter bit TICK_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_clk_div,
   input  logic [CNT_W-1:0] cfg_frame_len,
   input  logic [CNT_W-1:0] cfg_sync_len,
   input  logic             cfg_active_high,
   input  logic             cfg_free_run,
   input  logic             tx_pending,
   output logic             bclk,
   output logic             bclk_tick,
   output logic             fsync,
   output logic             frame_start
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("fsync_gen: DIV_W must be 1..16");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("fsync_gen: CNT_W must be 2..16");
      end
   endgenerate

   logic [DIV_W-1:0] act_div;
   logic [CNT_W-1:0] act_len;
   logic [CNT_W-1:0] act_wid;
   logic             act_pol;
   logic             tick_next;
   logic             running;
   logic             load;

   fsg_shadow #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_shadow (
      .clk             (clk),
      .rst_n           (rst_n),
      .load            (load),
      .cfg_clk_div     (cfg_clk_div),
      .cfg_frame_len   (cfg_frame_len),
      .cfg_sync_len    (cfg_sync_len),
      .cfg_active_high (cfg_active_high),
      .act_div         (act_div),
      .act_len         (act_len),
      .act_wid         (act_wid),
      .act_pol         (act_pol)
   );

   fsg_bitclk #(.DIV_W(DIV_W), .TICK_RISE(TICK_RISE)) u_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_div   (act_div),
      .bclk      (bclk),
      .bclk_tick (bclk_tick),
      .tick_next (tick_next)
   );

   fsg_framer #(.CNT_W(CNT_W)) u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_next   (tick_next),
      .free_run    (cfg_free_run),
      .pending     (tx_pending),
      .act_len     (act_len),
      .act_wid     (act_wid),
      .act_pol     (act_pol),
      .running     (running),
      .load        (load),
      .frame_start (frame_start),
      .fsync       (fsync)
   );

   // R12: frame start lands on a bit-clock tick
   a_r12_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> bclk_tick);
   // R12: single-cycle pulse
   a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   // R7: no sync while idle
   a_r7_idle_deasserted: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (fsync != act_pol));

endmodule

// File: tb/tb_fsync_gen.sv
module tb_fsync_gen;

   localparam int DIV_W = 8;
   localparam int CNT_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] cfg_clk_div = '0;
   logic [CNT_W-1:0] cfg_frame_len = '0;
   logic [CNT_W-1:0] cfg_sync_len = '0;
   logic             cfg_active_high = 1'b1;
   logic             cfg_free_run = 1'b0;
   logic             tx_pending = 1'b0;
   logic             bclk, bclk_tick, fsync, frame_start;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   fsync_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W), .TICK_RISE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_clk_div(cfg_clk_div),
      .cfg_frame_len(cfg_frame_len), .cfg_sync_len(cfg_sync_len),
      .cfg_active_high(cfg_active_high), .cfg_free_run(cfg_free_run),
      .tx_pending(tx_pending), .bclk(bclk), .bclk_tick(bclk_tick),
      .fsync(fsync), .frame_start(frame_start));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Advance to the next negedge showing bclk_tick; n = clock cycles taken.
   task automatic next_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!bclk_tick && n < 4000);
   endtask

   task automatic sync_start();
      int guard = 0;
      int n;
      do begin
         next_tick(n);
         guard++;
      end while (!frame_start && guard < 3000);
   endtask

   // Called positioned at a frame_start; ends at the next frame_start.
   task automatic measure_frame(input logic lvl, output int len, output int act, output int clks);
      int n;
      len = 0; act = 0; clks = 0;
      for (int i = 0; i < 3000; i++) begin
         if (fsync == lvl) act++;
         len++;
         next_tick(n);
         clks += n;
         if (frame_start) break;
      end
   endtask

   task automatic set_cfg(input int div, input int flen, input int slen, input logic pol, input logic fr);
      cfg_clk_div = div[DIV_W-1:0];
      cfg_frame_len = flen[CNT_W-1:0];
      cfg_sync_len = slen[CNT_W-1:0];
      cfg_active_high = pol;
      cfg_free_run = fr;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(bclk == 1'b0, "R1 bclk", int'(bclk), 0);
      chk(bclk_tick == 1'b0 && frame_start == 1'b0, "R1 strobes", int'(bclk_tick | frame_start), 0);
      chk(fsync == 1'b0, "R1 fsync", int'(fsync), 0);
   endtask

   task automatic t_divider(input int div);
      int n, hi, bad;
      set_cfg(div, 5, 1, 1'b1, 1'b1);
      sync_start();
      next_tick(n);
      hi = 0; bad = 0; n = 0;
      do begin
         @(negedge clk);
         n++;
         if (bclk) hi++;
         if (frame_start && !bclk_tick) bad++;
      end while (!bclk_tick && n < 4000);
      chk(n == 2 * (div + 1), "R2 tick spacing", n, 2 * (div + 1));
      chk(hi == div + 1, "R2 high phase", hi, div + 1);
      chk(bad == 0, "R12 start without tick", bad, 0);
   endtask

   task automatic t_shape(input string req, input int flen, input int slen, input logic pol);
      int len, act, clks;
      set_cfg(1, flen, slen, pol, 1'b1);
      sync_start();
      chk(fsync == pol, "R12 asserted at start", int'(fsync), int'(pol));
      measure_frame(pol, len, act, clks);
      chk(len == flen + 1, {req, " period"}, len, flen + 1);
      chk(act == ((slen >= flen) ? flen + 1 : slen + 1), {req, " width"}, act,
          (slen >= flen) ? flen + 1 : slen + 1);
   endtask

   task automatic t_i2s(input int nbits, input int div);
      int len, act, clks;
      set_cfg(div, 2 * nbits - 1, nbits - 1, 1'b0, 1'b1);
      sync_start();
      measure_frame(1'b0, len, act, clks);
      chk(act == nbits, "R11 low half", act, nbits);
      chk(len - act == nbits, "R11 high half", len - act, nbits);
      chk(clks == 2 * nbits * 2 * (div + 1), "R11 frame clocks", clks, 2 * nbits * 2 * (div + 1));
   endtask

   task automatic t_midframe();
      int len, act, clks, n;
      set_cfg(1, 7, 1, 1'b1, 1'b1);
      sync_start();
      @(negedge clk);
      cfg_frame_len = 3;
      cfg_clk_div = 0;
      if (bclk_tick) begin
         chk(1'b0, "R10 setup", 1, 0);
      end
      // measure from the start that was just seen: old settings
      len = 1; clks = 1;
      for (int i = 0; i < 100; i++) begin
         next_tick(n);
         clks += n;
         if (frame_start) break;
         len++;
      end
      chk(len == 8, "R10 old length kept", len, 8);
      chk(clks == 8 * 4, "R10 old spacing kept", clks, 32);
      next_tick(n);
      chk(n == 2, "R10 new spacing", n, 2);
      sync_start();
      measure_frame(1'b1, len, act, clks);
      chk(len == 4, "R10 new length", len, 4);
   endtask

   task automatic t_idle_and_pending();
      int starts, act, n;
      set_cfg(1, 3, 0, 1'b1, 1'b0);
      tx_pending = 1'b0;
      for (int i = 0; i < 10; i++) next_tick(n);
      starts = 0; act = 0;
      for (int i = 0; i < 20; i++) begin
         next_tick(n);
         if (frame_start) starts++;
         if (fsync) act++;
      end
      chk(starts == 0, "R7 no frames", starts, 0);
      chk(act == 0, "R7 sync idle", act, 0);
      tx_pending = 1'b1;
      next_tick(n);
      chk(frame_start == 1'b1, "R8 start on next tick", int'(frame_start), 1);
   endtask

   task automatic t_pending_drop();
      int starts, act, n;
      set_cfg(1, 9, 2, 1'b1, 1'b0);
      tx_pending = 1'b1;
      sync_start();
      tx_pending = 1'b0;
      starts = 0; act = (fsync == 1'b1) ? 1 : 0;
      for (int i = 0; i < 16; i++) begin
         next_tick(n);
         if (frame_start) starts++;
         if (fsync) act++;
      end
      chk(act == 3, "R9 full width", act, 3);
      chk(starts == 0, "R9 no new frame", starts, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_divider(0);
      t_divider(4);
      t_shape("R3 R4 codec pulse", 15, 0, 1'b1);
      t_shape("R5 active low", 5, 1, 1'b0);
      t_shape("R5 active high", 5, 2, 1'b1);
      t_shape("R6 width over period", 3, 5, 1'b1);
      t_shape("R6 width equal period", 3, 3, 1'b1);
      t_i2s(4, 1);
      t_i2s(6, 0);
      t_midframe();
      t_idle_and_pending();
      t_pending_drop();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule